// File: doc/BRIEF.md
# Single-Bus Datapath with Hardwired Step Sequencer

This block is a small processor core in which every register transfer travels over one shared internal bus, with exactly one source driving it in any cycle. It holds a parameterised bank of general registers, a program counter, an instruction register, a memory address register, a memory data register, an operand latch feeding the adder and a result latch catching its output. The adder's first operand comes either from the operand latch or from a fixed increment constant. Its second operand is always the bus.

A hardwired step counter emits the per-step load and drive strobes. Three fetch steps are common to every instruction. From the fourth step on, the opcode held in the instruction register selects the remaining steps. The core executes register move, register add, load, store and an add with a memory operand.

External memory is reached through an address, a read strobe, a write strobe, read and write data, and a completion input. Any step that waits on memory holds the counter until completion is signalled, so memory latency may vary from access to access.

Top module: `sbus_core`

## Requirements
- R1: While `rst_n` is low, `mem_rd` and `mem_wr` are low. In the first cycle after reset is released, a read is requested with `mem_addr` equal to `RESET_PC`.
- R2: Every instruction is read from the address held in the program counter. The program counter is advanced by `PC_INC` (default 4) through the adder, so back-to-back instruction reads use addresses that differ by `PC_INC`.
- R3: In every cycle, at most one of the internal sources (program counter, data register, result latch, one general register) drives the internal bus.
- R4: A step that waits for memory holds the step counter until `mem_mfc` is high. If a request first shows in cycle k and `mem_mfc` is high in cycle k+D, a register move (opcode 1) takes D+4 cycles from one instruction end to the next.
- R5: An instruction word carries the opcode in bits [DW-1:DW-4], the destination index d in bits [RIW-1:0], the first source index s in bits [2*RIW-1:RIW] and the second source index t in bits [3*RIW-1:2*RIW]. Opcode 1 copies register s into register d.
- R6: Opcode 2 writes register s plus register t, modulo 2^DW, into register d, and takes D+6 cycles.
- R7: Opcode 3 loads the memory word at the address in register s into register d, and takes 2D+6 cycles.
- R8: Opcode 4 writes register t to the memory word at the address in register s. `mem_wr` stays high from its first cycle through the cycle in which `mem_mfc` is high (D+1 cycles), and the instruction takes 2D+6 cycles.
- R9: Opcode 5 writes register d plus the memory word at the address in register s into register d, in seven steps and 2D+7 cycles. This holds even when d equals s.
- R10: Any other opcode changes no register and no memory word, and ends in the step right after the fetch (D+4 cycles).
- R11: `instr_end` pulses for one cycle in the last step of each instruction. In the next cycle the counter is back at the first fetch step, so the following instruction read starts right away.
- R12: `mem_rd` and `mem_wr` are never high together. Once raised, a request stays high until the cycle in which `mem_mfc` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | DW | Byte address from the memory address register |
| mem_rd | output | 1 | Read request, held until completion |
| mem_wr | output | 1 | Write request, held until completion |
| mem_wdata | output | DW | Write data, driven from the data register during the write wait step |
| mem_rdata | input | DW | Read data, sampled in the completion cycle |
| mem_mfc | input | 1 | Memory completion, high for one cycle per access |
| instr_end | output | 1 | High in the final cycle of each instruction |

## Verification
In the second fetch step, the program counter takes the incremented value from the result latch in the same cycles that the core waits for the instruction word to arrive. The same overlap occurs when the operand latch is loaded during the wait for a memory operand. Both are provoked by varying the memory delay from one to six cycles across the tests. The overlap is judged by the next fetch address and by the exact end-to-end cycle count of each instruction. A wrong overlap would show up as a skipped or repeated address, or as a count that is off by the stall length.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

   localparam int unsigned OP_W   = 4;
   localparam int unsigned STEP_W = 3;

   typedef logic [OP_W-1:0]   opcode_t;
   typedef logic [STEP_W-1:0] step_t;

   localparam opcode_t OPC_MOVE  = 4'd1;
   localparam opcode_t OPC_ADDR  = 4'd2;
   localparam opcode_t OPC_LOAD  = 4'd3;
   localparam opcode_t OPC_STORE = 4'd4;
   localparam opcode_t OPC_ADDM  = 4'd5;

   localparam step_t STP_1 = 3'd0;
   localparam step_t STP_2 = 3'd1;
   localparam step_t STP_3 = 3'd2;
   localparam step_t STP_4 = 3'd3;
   localparam step_t STP_5 = 3'd4;
   localparam step_t STP_6 = 3'd5;
   localparam step_t STP_7 = 3'd6;

   // one strobe per datapath action; register gating travels separately
   typedef struct packed {
      logic pc_out;
      logic pc_in;
      logic mar_in;
      logic ir_in;
      logic mdr_in;
      logic mdr_out;
      logic mdr_ld_ext;
      logic mdr_drv_ext;
      logic y_in;
      logic z_in;
      logic z_out;
      logic sel_inc;
      logic alu_add;
      logic rd_req;
      logic wr_req;
      logic wait_mfc;
      logic fin;
   } ctl_t;

endpackage

// File: rtl/sbus_alu.sv
module sbus_alu #(
   parameter int unsigned DW     = 32,
   parameter int unsigned PC_INC = 4
) (
   input  logic          sel_inc,
   input  logic          add_en,
   input  logic [DW-1:0] y_val,
   input  logic [DW-1:0] bus_val,
   output logic [DW-1:0] result
);

   localparam logic [DW-1:0] INC_C = DW'(PC_INC);

   logic [DW-1:0] opnd_a;

   always_comb begin
      opnd_a = sel_inc ? INC_C : y_val;
      result = add_en ? (opnd_a + bus_val) : bus_val;
   end

endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
   parameter int unsigned DW   = 32,
   parameter int unsigned NREG = 4,
   localparam int unsigned RIW = $clog2(NREG)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ld_en,
   input  logic [RIW-1:0] ld_idx,
   input  logic [DW-1:0]  ld_data,
   input  logic           drv_en,
   input  logic [RIW-1:0] drv_idx,
   output logic [DW-1:0]  drv_data
);

   logic [DW-1:0] q [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            q[i] <= '0;
         else if (ld_en && (ld_idx == RIW'(i)))
            q[i] <= ld_data;
      end
   end

   assign drv_data = drv_en ? q[drv_idx] : '0;

endmodule

// File: rtl/sbus_seq.sv
module sbus_seq
   import sbus_pkg::*;
#(
   parameter int unsigned RIW = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  opcode_t        op,
   input  logic [RIW-1:0] fld_d,
   input  logic [RIW-1:0] fld_s,
   input  logic [RIW-1:0] fld_t,
   input  logic           mfc,
   output ctl_t           ctl,
   output logic           r_out_en,
   output logic [RIW-1:0] r_out_idx,
   output logic           r_in_en,
   output logic [RIW-1:0] r_in_idx,
   output step_t          step,
   output logic           done
);

   logic stall;

   always_comb begin
      ctl       = '0;
      r_out_en  = 1'b0;
      r_out_idx = '0;
      r_in_en   = 1'b0;
      r_in_idx  = '0;
      case (step)
         STP_1: begin
            ctl.pc_out  = 1'b1;
            ctl.mar_in  = 1'b1;
            ctl.rd_req  = 1'b1;
            ctl.sel_inc = 1'b1;
            ctl.alu_add = 1'b1;
            ctl.z_in    = 1'b1;
         end
         STP_2: begin
            ctl.z_out      = 1'b1;
            ctl.pc_in      = 1'b1;
            ctl.y_in       = 1'b1;
            ctl.wait_mfc   = 1'b1;
            ctl.mdr_ld_ext = 1'b1;
         end
         STP_3: begin
            ctl.mdr_out = 1'b1;
            ctl.ir_in   = 1'b1;
         end
         STP_4: begin
            case (op)
               OPC_MOVE: begin
                  r_out_en = 1'b1; r_out_idx = fld_s;
                  r_in_en  = 1'b1; r_in_idx  = fld_d;
                  ctl.fin  = 1'b1;
               end
               OPC_ADDR: begin
                  r_out_en = 1'b1; r_out_idx = fld_s;
                  ctl.y_in = 1'b1;
               end
               OPC_LOAD, OPC_ADDM: begin
                  r_out_en   = 1'b1; r_out_idx = fld_s;
                  ctl.mar_in = 1'b1;
                  ctl.rd_req = 1'b1;
               end
               OPC_STORE: begin
                  r_out_en   = 1'b1; r_out_idx = fld_s;
                  ctl.mar_in = 1'b1;
               end
               default: ctl.fin = 1'b1;
            endcase
         end
         STP_5: begin
            case (op)
               OPC_ADDR: begin
                  r_out_en    = 1'b1; r_out_idx = fld_t;
                  ctl.alu_add = 1'b1;
                  ctl.z_in    = 1'b1;
               end
               OPC_LOAD: begin
                  ctl.mdr_ld_ext = 1'b1;
                  ctl.wait_mfc   = 1'b1;
               end
               OPC_STORE: begin
                  r_out_en   = 1'b1; r_out_idx = fld_t;
                  ctl.mdr_in = 1'b1;
                  ctl.wr_req = 1'b1;
               end
               OPC_ADDM: begin
                  r_out_en       = 1'b1; r_out_idx = fld_d;
                  ctl.y_in       = 1'b1;
                  ctl.mdr_ld_ext = 1'b1;
                  ctl.wait_mfc   = 1'b1;
               end
               default: ctl.fin = 1'b1;
            endcase
         end
         STP_6: begin
            case (op)
               OPC_ADDR: begin
                  ctl.z_out = 1'b1;
                  r_in_en   = 1'b1; r_in_idx = fld_d;
                  ctl.fin   = 1'b1;
               end
               OPC_LOAD: begin
                  ctl.mdr_out = 1'b1;
                  r_in_en     = 1'b1; r_in_idx = fld_d;
                  ctl.fin     = 1'b1;
               end
               OPC_STORE: begin
                  ctl.mdr_drv_ext = 1'b1;
                  ctl.wait_mfc    = 1'b1;
                  ctl.fin         = 1'b1;
               end
               OPC_ADDM: begin
                  ctl.mdr_out = 1'b1;
                  ctl.alu_add = 1'b1;
                  ctl.z_in    = 1'b1;
               end
               default: ctl.fin = 1'b1;
            endcase
         end
         STP_7: begin
            if (op == OPC_ADDM) begin
               ctl.z_out = 1'b1;
               r_in_en   = 1'b1; r_in_idx = fld_d;
            end
            ctl.fin = 1'b1;
         end
         default: ctl.fin = 1'b1;
      endcase
   end

   assign stall = ctl.wait_mfc && !mfc;
   assign done  = ctl.fin && !stall;

   always_ff @(posedge clk) begin
      if (!rst_n)
         step <= STP_1;
      else if (stall)
         step <= step;
      else if (ctl.fin)
         step <= STP_1;
      else
         step <= step + 3'd1;
   end

endmodule

// File: rtl/sbus_core.sv
module sbus_core
   import sbus_pkg::*;
#(
   parameter int unsigned DW       = 32,
   parameter int unsigned NREG     = 4,
   parameter int unsigned PC_INC   = 4,
   parameter logic [DW-1:0] RESET_PC = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [DW-1:0] mem_addr,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_mfc,
   output logic          instr_end
);

   localparam int unsigned RIW  = $clog2(NREG);
   localparam int unsigned IRW  = OP_W + 3 * RIW;
   localparam int unsigned NDRV = 4;

   if (NREG < 2 || (1 << RIW) != NREG) begin : g_bad_nreg
      $error("sbus_core: NREG must be a power of two, at least 2");
   end
   if (DW < IRW) begin : g_bad_dw
      $error("sbus_core: DW too narrow for opcode and register fields");
   end
   if (PC_INC == 0 || (RESET_PC % DW'(PC_INC)) != '0) begin : g_bad_pc
      $error("sbus_core: RESET_PC must be a multiple of a nonzero PC_INC");
   end

   ctl_t           ctl;
   step_t          step;
   logic           r_out_en, r_in_en;
   logic [RIW-1:0] r_out_idx, r_in_idx;

   logic [DW-1:0]  pc, mar, mdr, y_lat, z_lat;
   logic [IRW-1:0] ir;
   logic [DW-1:0]  bus, rf_drv, alu_res;
   logic           rd_pend, wr_pend;
   logic [NDRV-1:0] drv;

   sbus_seq #(.RIW(RIW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (ir[IRW-1 -: OP_W]),
      .fld_d     (ir[RIW-1:0]),
      .fld_s     (ir[2*RIW-1:RIW]),
      .fld_t     (ir[3*RIW-1:2*RIW]),
      .mfc       (mem_mfc),
      .ctl       (ctl),
      .r_out_en  (r_out_en),
      .r_out_idx (r_out_idx),
      .r_in_en   (r_in_en),
      .r_in_idx  (r_in_idx),
      .step      (step),
      .done      (instr_end)
   );

   sbus_regfile #(.DW(DW), .NREG(NREG)) u_rf (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en    (r_in_en),
      .ld_idx   (r_in_idx),
      .ld_data  (bus),
      .drv_en   (r_out_en),
      .drv_idx  (r_out_idx),
      .drv_data (rf_drv)
   );

   sbus_alu #(.DW(DW), .PC_INC(PC_INC)) u_alu (
      .sel_inc (ctl.sel_inc),
      .add_en  (ctl.alu_add),
      .y_val   (y_lat),
      .bus_val (bus),
      .result  (alu_res)
   );

   // bus sources merged by AND-OR; the sequencer enables one at a time
   assign drv = {ctl.pc_out, ctl.mdr_out, ctl.z_out, r_out_en};

   always_comb begin
      bus = rf_drv;
      if (ctl.pc_out)  bus = bus | pc;
      if (ctl.mdr_out) bus = bus | mdr;
      if (ctl.z_out)   bus = bus | z_lat;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc    <= RESET_PC;
         mar   <= '0;
         ir    <= '0;
         y_lat <= '0;
         z_lat <= '0;
         mdr   <= '0;
      end else begin
         if (ctl.pc_in)  pc    <= bus;
         if (ctl.mar_in) mar   <= bus;
         if (ctl.ir_in)  ir    <= {bus[DW-1 -: OP_W], bus[3*RIW-1:0]};
         if (ctl.y_in)   y_lat <= bus;
         if (ctl.z_in)   z_lat <= alu_res;
         if (ctl.mdr_ld_ext && mem_mfc)
            mdr <= mem_rdata;
         else if (ctl.mdr_in)
            mdr <= bus;
      end
   end

   // requests persist until the memory reports completion
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_pend <= 1'b0;
         wr_pend <= 1'b0;
      end else begin
         rd_pend <= ctl.rd_req | (rd_pend & ~mem_mfc);
         wr_pend <= ctl.wr_req | (wr_pend & ~mem_mfc);
      end
   end

   assign mem_addr  = mar;
   assign mem_rd    = rd_pend;
   assign mem_wr    = wr_pend;
   assign mem_wdata = ctl.mdr_drv_ext ? mdr : '0;

endmodule

// File: rtl/sbus_core_chk.sv
module sbus_core_chk
   import sbus_pkg::*;
#(
   parameter int unsigned DW     = 32,
   parameter int unsigned PC_INC = 4
) (
   input logic          clk,
   input logic          rst_n,
   input step_t         step,
   input logic [3:0]    drv,
   input logic          wait_mfc,
   input logic          instr_end,
   input logic          mem_mfc,
   input logic          mem_rd,
   input logic          mem_wr,
   input logic [DW-1:0] pc,
   input logic [DW-1:0] mar
);

   AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(drv)); // R3

   AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_mfc && !mem_mfc) |=> $stable(step)); // R4

   AST_END_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      instr_end |=> (step == STP_1)); // R11

   AST_FETCH_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (step == STP_3) |-> (pc == mar + DW'(PC_INC))); // R2

   AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr)); // R12

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !mem_mfc) |=> mem_rd); // R12

   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && !mem_mfc) |=> mem_wr); // R8

endmodule

bind sbus_core sbus_core_chk #(.DW(DW), .PC_INC(PC_INC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .step      (step),
   .drv       (drv),
   .wait_mfc  (ctl.wait_mfc),
   .instr_end (instr_end),
   .mem_mfc   (mem_mfc),
   .mem_rd    (mem_rd),
   .mem_wr    (mem_wr),
   .pc        (pc),
   .mar       (mar)
);

// File: tb/sbus_core_test.sv
module sbus_core_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_rd, mem_wr, instr_end;
   logic        mem_mfc = 1'b0;

   always #10 clk = ~clk;

   sbus_core #(.DW(32), .NREG(4), .PC_INC(4), .RESET_PC(32'h40)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_mfc   (mem_mfc),
      .instr_end (instr_end)
   );

   logic [31:0] mem [128];
   int lat = 0;
   int cnt = 0;
   int ncyc = 0;
   int n_end = 0;
   int n_rd = 0;
   int wr_cyc = 0;
   int both_cyc = 0;
   int end_cyc [32];
   logic [31:0] rd_log [32];
   int n_tests = 0;
   int n_fail = 0;

   function automatic logic [31:0] enc(logic [3:0] op, logic [1:0] d, logic [1:0] s, logic [1:0] t);
      return {op, 22'd0, t, s, d};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // memory: answers each request after lat extra cycles (delay D = lat+1)
   task automatic mem_loop();
      forever begin
         @(posedge clk);
         ncyc++;
         if (!rst_n) begin
            mem_mfc <= 1'b0;
            cnt = 0; n_end = 0; n_rd = 0; wr_cyc = 0; both_cyc = 0;
         end else begin
            if (instr_end && n_end < 32) begin
               end_cyc[n_end] = ncyc;
               n_end++;
            end
            if (mem_wr) wr_cyc++;
            if (mem_rd && mem_wr) both_cyc++;
            if ((mem_rd || mem_wr) && !mem_mfc) begin
               if (cnt == 0 && mem_rd && n_rd < 32) begin
                  rd_log[n_rd] = mem_addr;
                  n_rd++;
               end
               if (cnt == lat) begin
                  mem_mfc <= 1'b1;
                  cnt = 0;
                  if (mem_rd) mem_rdata <= mem[mem_addr[8:2]];
                  if (mem_wr) mem[mem_addr[8:2]] = mem_wdata;
               end else begin
                  cnt++;
               end
            end else begin
               mem_mfc <= 1'b0;
            end
         end
      end
   endtask

   task automatic watchdog();
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < 128; i++) mem[i] = '0;
      repeat (2) @(negedge clk);
   endtask

   task automatic run(input int n, input int l);
      lat = l;
      rst_n = 1'b1;
      for (int i = 0; i < 3000 && n_end < n; i++) @(negedge clk);
      n_tests++;
      if (n_end < n) begin
         n_fail++;
         $display("FAIL run: actual %0d instructions expected %0d", n_end, n);
      end
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 rd low in reset", 32'(mem_rd), 32'd0);
      chk("R1 wr low in reset", 32'(mem_wr), 32'd0);
      lat = 0;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 first read", 32'(mem_rd), 32'd1);
      chk("R1 first address", mem_addr, 32'h40);
   endtask

   // R3: a second bus source would corrupt every transferred value below
   task automatic t_move_load_store();
      do_reset();
      mem[0]  = 32'h100;
      mem[64] = 32'h1234_5678;
      mem[16] = enc(4'd3, 2'd1, 2'd0, 2'd0);
      mem[17] = enc(4'd3, 2'd2, 2'd1, 2'd0);
      mem[18] = enc(4'd1, 2'd3, 2'd2, 2'd0);
      mem[19] = enc(4'd4, 2'd0, 2'd0, 2'd3);
      run(4, 0);
      chk("R5 R7 R8 R3 moved value stored", mem[0], 32'h1234_5678);
      chk("R7 load cycles D=1", 32'(end_cyc[1] - end_cyc[0]), 32'd8);
      chk("R4 move cycles D=1", 32'(end_cyc[2] - end_cyc[1]), 32'd5);
      chk("R8 store cycles D=1", 32'(end_cyc[3] - end_cyc[2]), 32'd8);
      chk("R2 fetch addr 3", rd_log[4], 32'h48);
      chk("R2 fetch addr 4", rd_log[5], 32'h4C);
   endtask

   task automatic t_add();
      do_reset();
      mem[0]  = 32'h100;
      mem[64] = 32'h8000_0003;
      mem[16] = enc(4'd3, 2'd1, 2'd0, 2'd0);
      mem[17] = enc(4'd3, 2'd2, 2'd1, 2'd0);
      mem[18] = enc(4'd2, 2'd3, 2'd2, 2'd2);
      mem[19] = enc(4'd2, 2'd3, 2'd3, 2'd1);
      mem[20] = enc(4'd4, 2'd0, 2'd0, 2'd3);
      run(5, 2);
      chk("R6 add with wrap", mem[0], 32'h106);
      chk("R6 add cycles D=3", 32'(end_cyc[2] - end_cyc[1]), 32'd9);
      chk("R8 store cycles D=3", 32'(end_cyc[4] - end_cyc[3]), 32'd12);
      chk("R8 write held cycles", 32'(wr_cyc), 32'd4);
      chk("R12 no read with write", 32'(both_cyc), 32'd0);
   endtask

   task automatic t_addmem();
      do_reset();
      mem[0]  = 32'h100;
      mem[64] = 32'h55;
      mem[16] = enc(4'd3, 2'd1, 2'd0, 2'd0);
      mem[17] = enc(4'd5, 2'd1, 2'd1, 2'd0);
      mem[18] = enc(4'd4, 2'd0, 2'd0, 2'd1);
      run(3, 3);
      chk("R9 memory add, d equals s", mem[0], 32'h155);
      chk("R9 memory add cycles D=4", 32'(end_cyc[1] - end_cyc[0]), 32'd15);
   endtask

   task automatic t_undefined();
      do_reset();
      mem[0]  = 32'h100;
      mem[64] = 32'hABCD;
      mem[16] = enc(4'd3, 2'd1, 2'd0, 2'd0);
      mem[17] = enc(4'd3, 2'd2, 2'd1, 2'd0);
      mem[18] = enc(4'd15, 2'd2, 2'd1, 2'd1);
      mem[19] = enc(4'd0, 2'd2, 2'd2, 2'd2);
      mem[20] = enc(4'd4, 2'd0, 2'd0, 2'd2);
      run(5, 1);
      chk("R10 register kept", mem[0], 32'hABCD);
      chk("R10 pointed word kept", mem[64], 32'hABCD);
      chk("R10 undefined cycles D=2", 32'(end_cyc[2] - end_cyc[1]), 32'd6);
      chk("R10 only the store writes", 32'(wr_cyc), 32'd3);
   endtask

   task automatic t_slow_memory();
      do_reset();
      mem[0]  = 32'h100;
      mem[16] = enc(4'd3, 2'd1, 2'd0, 2'd0);
      mem[17] = enc(4'd1, 2'd2, 2'd1, 2'd0);
      mem[18] = enc(4'd1, 2'd3, 2'd2, 2'd0);
      mem[19] = enc(4'd4, 2'd0, 2'd0, 2'd3);
      run(4, 5);
      chk("R4 move cycles D=6", 32'(end_cyc[1] - end_cyc[0]), 32'd10);
      chk("R11 move restart D=6", 32'(end_cyc[2] - end_cyc[1]), 32'd10);
      chk("R2 fetch addr 2", rd_log[2], 32'h44);
      chk("R2 fetch addr 3", rd_log[3], 32'h48);
      chk("R11 fetch after end", rd_log[4], 32'h4C);
   endtask

   initial begin
      fork
         mem_loop();
         watchdog();
      join_none
      t_reset();
      t_move_load_store();
      t_add();
      t_addmem();
      t_undefined();
      t_slow_memory();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule